// File: doc/BRIEF.md
# Prescaled Up-Counting Timer with Update Events

This block is the counting core of a general-purpose timer. A prescaler divides the clock by a programmable ratio. Each prescaler period advances a counter that returns to zero after it reaches its reload limit. The return to zero is an update event, and so is a software update request. An update event copies the buffered prescaler ratio and the buffered reload limit into their working registers. It also raises a sticky flag, which can drive an interrupt request.

The inputs model register fields written by software. Level fields select the modes: update disable, update request source, one-pulse, reload buffering, flag remapping and interrupt enable. One-cycle pulses do the writes: counter enable, prescaler value, reload value, software update and flag clear. In one-pulse mode the block clears its own enable at an update event. The read value packs the counter into its low bits and can carry the flag in bit 31.

Top module: `tmr_core`

## Requirements
- R1: After an asynchronous reset the counter, flag, interrupt request, update pulse, enable and read value are all 0; the working prescaler ratio and both reload registers are 0.
- R2: While enabled, the counter advances by one at the end of each prescaler period. When it advances from a value equal to the working reload limit, it returns to 0, and update_o is high for exactly that one clock.
- R3: With udis_i high, neither overflow nor ug_i produces an update pulse, sets the flag or loads a working register. ug_i still clears the counter and the prescaler counter at the next edge.
- R4: With udis_i low, a one-cycle ug_i clears the counter and the prescaler counter at the next edge. It produces update_o at that edge and loads the working prescaler ratio and reload registers. It has priority over counting in the same cycle.
- R5: With urs_i high, only overflow sets the flag. With urs_i low, both overflow and ug_i set it. Both sources produce update_o in either setting.
- R6: The counter advances once per psc+1 enabled clocks, where psc is the working ratio. A value written through psc_we_i becomes the working ratio only at the next update event.
- R7: With arpe_i low, the limit is the last value written through arr_we_i, effective from the edge after the write. With arpe_i high, the limit is a working copy that is loaded from the written value only at an update event.
- R8: With opm_i high, an update event clears the enable at the same edge, and the counter then holds. This clear has priority over a cen_we_i write in the same cycle.
- R9: The flag is set by a qualifying update event and stays set until uif_clr_i; a set and a clear in the same cycle leave it set. irq_o is high exactly when the flag and uie_i are both high.
- R10: cnt_rd_o carries the counter in bits 15:0 and zeros in bits 30:16. Bit 31 equals the flag when remap_i is high and is 0 otherwise.
- R11: A cen_we_i pulse loads cen_wdata_i into the enable at the next edge. While the enable is low, the counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_we_i | input | 1 | Enable write strobe |
| cen_wdata_i | input | 1 | Enable write value |
| udis_i | input | 1 | Update disable |
| urs_i | input | 1 | Update request source: 1 = overflow only sets the flag |
| opm_i | input | 1 | One-pulse mode |
| arpe_i | input | 1 | Reload buffering enable |
| remap_i | input | 1 | Copy the flag into read bit 31 |
| uie_i | input | 1 | Update interrupt enable |
| ug_i | input | 1 | Software update request pulse |
| uif_clr_i | input | 1 | Flag clear pulse |
| psc_we_i | input | 1 | Prescaler write strobe |
| psc_wdata_i | input | PSC_W | Prescaler write value |
| arr_we_i | input | 1 | Reload write strobe |
| arr_wdata_i | input | CNT_W | Reload write value |
| cnt_o | output | CNT_W | Counter value |
| cnt_rd_o | output | 32 | Counter read value with optional flag copy |
| update_o | output | 1 | Update event pulse |
| uif_o | output | 1 | Sticky update flag |
| irq_o | output | 1 | Update interrupt request |
| cen_o | output | 1 | Counter enable state |

## Verification
The bench uses the default widths of 16 bits for both the counter and the prescaler. It programs small reload limits (5 and 2) and small ratios (0 and 2), so that several overflows happen within about a hundred cycles. This makes it possible to observe when the working ratio and limit change in relation to update events. It checks that udis_i, urs_i and opm_i each change the update pulse, the flag and the enable at the exact edges they should.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned RD_W = 32;

  typedef struct packed {
    logic udis;
    logic urs;
    logic opm;
    logic arpe;
  } tmr_mode_t;
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [PSC_W-1:0] ratio_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] div_q;

  assign tick_o = run_i && (div_q == ratio_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (tick_o) div_q <= '0;
    else if (run_i)  div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = tick_i && (cnt_q == limit_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_upd.sv
module tmr_upd
  import tmr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  tmr_mode_t mode_i,
  input  logic      wrap_i,
  input  logic      ug_i,
  input  logic      cen_we_i,
  input  logic      cen_wdata_i,
  input  logic      uif_clr_i,
  input  logic      uie_i,
  output logic      uev_o,
  output logic      update_o,
  output logic      cen_o,
  output logic      uif_o,
  output logic      irq_o
);
  logic flag_set;
  logic update_q, cen_q, uif_q;

  assign uev_o    = !mode_i.udis && (wrap_i || ug_i);
  // request source gates the flag only, not the event itself
  assign flag_set = uev_o && (wrap_i || !mode_i.urs);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      update_q <= 1'b0;
      cen_q    <= 1'b0;
      uif_q    <= 1'b0;
    end else begin
      update_q <= uev_o;
      if (uev_o && mode_i.opm) cen_q <= 1'b0;
      else if (cen_we_i)       cen_q <= cen_wdata_i;
      if (flag_set)            uif_q <= 1'b1;
      else if (uif_clr_i)      uif_q <= 1'b0;
    end
  end

  assign update_o = update_q;
  assign cen_o    = cen_q;
  assign uif_o    = uif_q;
  assign irq_o    = uif_q && uie_i;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cen_we_i,
  input  logic             cen_wdata_i,
  input  logic             udis_i,
  input  logic             urs_i,
  input  logic             opm_i,
  input  logic             arpe_i,
  input  logic             remap_i,
  input  logic             uie_i,
  input  logic             ug_i,
  input  logic             uif_clr_i,
  input  logic             psc_we_i,
  input  logic [PSC_W-1:0] psc_wdata_i,
  input  logic             arr_we_i,
  input  logic [CNT_W-1:0] arr_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [RD_W-1:0]  cnt_rd_o,
  output logic             update_o,
  output logic             uif_o,
  output logic             irq_o,
  output logic             cen_o
);
  localparam int unsigned PAD_W = RD_W - 1 - CNT_W;

  tmr_mode_t        mode;
  logic [PSC_W-1:0] psc_pre_q, psc_act_q;
  logic [CNT_W-1:0] arr_pre_q, arr_sh_q, limit;
  logic             tick, wrap, uev, cen;
  logic [CNT_W-1:0] cnt;

  assign mode = '{udis: udis_i, urs: urs_i, opm: opm_i, arpe: arpe_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_pre_q <= '0;
      psc_act_q <= '0;
      arr_pre_q <= '0;
      arr_sh_q  <= '0;
    end else begin
      if (psc_we_i) psc_pre_q <= psc_wdata_i;
      if (arr_we_i) arr_pre_q <= arr_wdata_i;
      if (uev) begin
        psc_act_q <= psc_pre_q;
        arr_sh_q  <= arr_pre_q;
      end
    end
  end

  // unbuffered reload reads the written register directly
  assign limit = mode.arpe ? arr_sh_q : arr_pre_q;

  tmr_presc #(.PSC_W(PSC_W)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (cen),
    .clr_i   (ug_i),
    .ratio_i (psc_act_q),
    .tick_o  (tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .clr_i   (ug_i),
    .limit_i (limit),
    .cnt_o   (cnt),
    .wrap_o  (wrap)
  );

  tmr_upd u_upd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .wrap_i      (wrap),
    .ug_i        (ug_i),
    .cen_we_i    (cen_we_i),
    .cen_wdata_i (cen_wdata_i),
    .uif_clr_i   (uif_clr_i),
    .uie_i       (uie_i),
    .uev_o       (uev),
    .update_o    (update_o),
    .cen_o       (cen),
    .uif_o       (uif_o),
    .irq_o       (irq_o)
  );

  assign cnt_o    = cnt;
  assign cen_o    = cen;
  assign cnt_rd_o = {remap_i & uif_o, {PAD_W{1'b0}}, cnt};
endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             udis_i,
  input logic             urs_i,
  input logic             opm_i,
  input logic             ug_i,
  input logic             uif_clr_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             update_o,
  input logic             uif_o,
  input logic             irq_o,
  input logic             cen_o
);
  AST_UDIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(udis_i) |-> !update_o); // R3

  AST_UPDATE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> cnt_o == '0); // R2

  AST_URS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uif_o) && $past(urs_i) |-> update_o); // R5

  AST_OPM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o && $past(opm_i) |-> !cen_o); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(uif_o) && !$past(uif_clr_i) |-> uif_o); // R9

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> uif_o); // R9

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cen_o) && !$past(ug_i) |-> $stable(cnt_o)); // R11
endmodule

bind tmr_core tmr_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .udis_i    (udis_i),
  .urs_i     (urs_i),
  .opm_i     (opm_i),
  .ug_i      (ug_i),
  .uif_clr_i (uif_clr_i),
  .cnt_o     (cnt_o),
  .update_o  (update_o),
  .uif_o     (uif_o),
  .irq_o     (irq_o),
  .cen_o     (cen_o)
);

// File: tb/sim_tmr_core.sv
module sim_tmr_core;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int PSC_W = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cen_we_i = 0, cen_wdata_i = 0, udis_i = 0, urs_i = 0, opm_i = 0;
  logic arpe_i = 0, remap_i = 0, uie_i = 0, ug_i = 0, uif_clr_i = 0;
  logic psc_we_i = 0, arr_we_i = 0;
  logic [PSC_W-1:0] psc_wdata_i = '0;
  logic [CNT_W-1:0] arr_wdata_i = '0;
  logic [CNT_W-1:0] cnt_o;
  logic [31:0]      cnt_rd_o;
  logic update_o, uif_o, irq_o, cen_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;
  int exp_q[$];

  tmr_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u0 (
    .clk_i, .rst_ni, .cen_we_i, .cen_wdata_i, .udis_i, .urs_i, .opm_i,
    .arpe_i, .remap_i, .uie_i, .ug_i, .uif_clr_i, .psc_we_i, .psc_wdata_i,
    .arr_we_i, .arr_wdata_i, .cnt_o, .cnt_rd_o, .update_o, .uif_o, .irq_o,
    .cen_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) if (rst_ni) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk_i);
  endtask

  // monitor: every update pulse must match the next expected cycle
  always @(negedge clk_i) begin
    if (rst_ni && update_o && !done) begin
      if (exp_q.size() == 0) chk("R2 unexpected update", cyc, 0);
      else chk("R2 update cycle", cyc, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int s, t;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1 cnt", cnt_o, 0);
    chk("R1 uif", uif_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 update", update_o, 0);
    chk("R1 cen", cen_o, 0);
    chk("R1 rd", cnt_rd_o, 0);

    // Phase A: free run, ratio 0, limit 5, unbuffered reload
    wait_cyc(2); s = cyc;
    arr_we_i = 1; arr_wdata_i = 5; cen_we_i = 1; cen_wdata_i = 1;
    exp_q.push_back(s + 7); exp_q.push_back(s + 13);
    wait_cyc(s + 1); arr_we_i = 0; cen_we_i = 0;
    wait_cyc(s + 4); chk("R2 cnt mid", cnt_o, 3); chk("R7 cen", cen_o, 1);
    wait_cyc(s + 7); chk("R2 wrap cnt", cnt_o, 0); chk("R9 flag set", uif_o, 1);
    chk("R9 irq gated", irq_o, 0);
    uie_i = 1;
    wait_cyc(s + 8); chk("R9 irq on", irq_o, 1); uif_clr_i = 1;
    wait_cyc(s + 9); uif_clr_i = 0; chk("R9 flag cleared", uif_o, 0); chk("R9 irq off", irq_o, 0);
    wait_cyc(s + 13); chk("R9 flag again", uif_o, 1); remap_i = 1;
    wait_cyc(s + 14); chk("R10 remap rd", cnt_rd_o, 32'h8000_0001);
    cen_we_i = 1; cen_wdata_i = 0;
    wait_cyc(s + 15); cen_we_i = 0; remap_i = 0;
    wait_cyc(s + 16); chk("R10 no remap rd", cnt_rd_o, 32'h0000_0002); uif_clr_i = 1;
    wait_cyc(s + 17); uif_clr_i = 0;
    chk("R11 held cnt", cnt_o, 2); chk("R11 cen off", cen_o, 0);

    // Phase B: buffered prescaler, loaded by software update
    wait_cyc(s + 18); t = cyc;
    psc_we_i = 1; psc_wdata_i = 2;
    wait_cyc(t + 1); psc_we_i = 0; cen_we_i = 1; cen_wdata_i = 1;
    wait_cyc(t + 2); cen_we_i = 0;
    wait_cyc(t + 4); chk("R6 ratio not yet loaded", cnt_o, 4);
    ug_i = 1; exp_q.push_back(t + 5);
    wait_cyc(t + 5); ug_i = 0;
    chk("R4 ug clears cnt", cnt_o, 0); chk("R5 ug sets flag", uif_o, 1);
    uif_clr_i = 1;
    wait_cyc(t + 6); uif_clr_i = 0;
    wait_cyc(t + 7); chk("R6 slow cnt a", cnt_o, 0);
    wait_cyc(t + 8); chk("R6 slow cnt b", cnt_o, 1);
    exp_q.push_back(t + 23);
    wait_cyc(t + 23); chk("R6 wrap", cnt_o, 0); uif_clr_i = 1;

    // Phase C: request source = overflow only
    wait_cyc(t + 24); uif_clr_i = 0; urs_i = 1; ug_i = 1; exp_q.push_back(t + 25);
    wait_cyc(t + 25); ug_i = 0;
    chk("R5 ug no flag", uif_o, 0); chk("R4 cnt clr", cnt_o, 0);
    exp_q.push_back(t + 43);
    wait_cyc(t + 43); chk("R5 overflow flag", uif_o, 1);

    // Phase D: update disabled
    wait_cyc(t + 44); urs_i = 0; udis_i = 1; uif_clr_i = 1; psc_we_i = 1; psc_wdata_i = 0;
    wait_cyc(t + 45); uif_clr_i = 0; psc_we_i = 0; ug_i = 1;
    wait_cyc(t + 46); ug_i = 0;
    chk("R3 ug clears cnt", cnt_o, 0); chk("R3 no flag", uif_o, 0);
    wait_cyc(t + 48); chk("R3 ratio kept a", cnt_o, 0);
    wait_cyc(t + 49); chk("R3 ratio kept b", cnt_o, 1);
    wait_cyc(t + 64); chk("R3 quiet wrap cnt", cnt_o, 0); chk("R3 quiet wrap flag", uif_o, 0);

    // Phase E: buffered reload and one-pulse mode
    wait_cyc(t + 65); udis_i = 0; arpe_i = 1; opm_i = 1; arr_we_i = 1; arr_wdata_i = 2;
    wait_cyc(t + 66); arr_we_i = 0;
    wait_cyc(t + 73); chk("R7 old limit kept", cnt_o, 3);
    exp_q.push_back(t + 82);
    wait_cyc(t + 82); chk("R8 opm clears cen", cen_o, 0); chk("R8 cnt", cnt_o, 0);
    wait_cyc(t + 85); chk("R8 stopped", cnt_o, 0);
    cen_we_i = 1; cen_wdata_i = 1;
    wait_cyc(t + 86); cen_we_i = 0;
    exp_q.push_back(t + 89);
    wait_cyc(t + 88); chk("R7 new limit reached", cnt_o, 2);
    wait_cyc(t + 89); chk("R7 wrap at new limit", cnt_o, 0); chk("R8 cen off again", cen_o, 0);

    wait_cyc(t + 95);
    chk("R2 all updates seen", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule